// File: doc/BRIEF.md
# Core Halt and Debug Controller

This block holds the control and status registers that let a host start, stop, single-step and reset a small embedded processor core, and that record why the core stopped. The host reaches two 32-bit registers through a simple read/write bus. One is the control register, at offset 0x0. The other is the halt-cause register, at offset 0x4. The core reports its instruction fetch and data access addresses, blocking cache misses, overflows of its two internal FIFOs, and watchdog expiry as single-cycle strobes.

Fetches and data accesses that land in the lowest 256 bytes of memory can be trapped when their enables are set. FIFO overflows always stop the core. Cache misses are recorded for information only. Every latched cause is cleared by writing a 1 to it. The host can release the core for exactly one cycle with a single-step pulse. After that cycle the core stops again if any cause is still latched. The host can also reset only the core with a one-cycle pulse.

Top module: `core_halt_ctrl`

## Requirements
- R1: After reset, core_halt, core_step and core_reset are 0. The control register reads 0x0000_0040, with only the boot-failure flag (bit 6) set. The cause register reads 0.
- R2: Control bit 2 enables the fetch trap. While it is 1, a fetch strobe whose address is below 256 sets cause bit 4. A fetch at 256 or above, or with the enable at 0, sets nothing.
- R3: Control bit 3 enables the data trap. While it is 1, a data-access strobe whose address is below 256 sets cause bit 3. An access at 256 or above, or with the enable at 0, sets nothing.
- R4: A request-FIFO overflow strobe sets cause bit 30, and a mask-FIFO overflow strobe sets cause bit 29. Both set their bit and halt the core whatever the control bits hold.
- R5: A cache-miss strobe sets cause bit 31 and never causes core_halt by itself.
- R6: Writing to offset 0x4 clears each cause bit written as 1 and leaves bits written as 0 unchanged. If a cause event and its clear arrive in the same cycle, the bit stays set.
- R7: core_halt is 1 in the cycle after any of cause bits 30, 29, 4 or 3 becomes set. It falls in the cycle after the last of them is cleared.
- R8: Writing 1 to control bit 0 raises core_step for exactly one cycle, during which core_halt is 0. In the following cycle core_halt is 1 again if any halt-class cause is still latched.
- R9: Writing 1 to control bit 1 raises core_reset for exactly one cycle. The other control bits and the cause register are unchanged.
- R10: A watchdog strobe clears control bits 7 (watchdog enable), 3 and 2, and leaves the other control bits alone. It wins over a host write to those bits in the same cycle.
- R11: Control bits 4 (write-post enable), 5 (data-cache enable) and 6 (boot-failure flag) read back as written.
- R12: A read returns its data on bus_rdata in the cycle after bus_rd. Reads of unused cause bits, and reads of any offset other than 0x0 and 0x4, return 0. Writes to other offsets change nothing. Control bits 0 and 1 read back as the current core_step and core_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | CORE_AW | Instruction fetch address |
| dacc_vld | input | 1 | Data access strobe |
| dacc_addr | input | CORE_AW | Data access address |
| cache_miss | input | 1 | Blocking cache miss strobe |
| req_fifo_ovf | input | 1 | Request FIFO overflow strobe |
| mask_fifo_ovf | input | 1 | Data/mask FIFO overflow strobe |
| wdog_evt | input | 1 | Watchdog expiry strobe |
| core_halt | output | 1 | Holds the core stopped |
| core_step | output | 1 | One-cycle release for single-step |
| core_reset | output | 1 | One-cycle reset of the core only |

## Verification
Each register here is one flop deep, so every result is due exactly one clock edge after its stimulus. Cause bits, control bits, core_halt, core_step, core_reset and read data all appear on the edge that follows the strobe or bus cycle. A read therefore returns the register as it stood before that edge. The bench drives its inputs on the falling edge and compares all outputs on the next falling edge against a model it has advanced by one step. A read issued together with a write must show the value from before the write. The re-halt after a single-step is checked one further edge later.

// File: rtl/core_dbg_pkg.sv
package core_dbg_pkg;
  // control register bit positions
  localparam int CB_STEP   = 0;
  localparam int CB_CRST   = 1;
  localparam int CB_FTRAP  = 2;
  localparam int CB_DTRAP  = 3;
  localparam int CB_WPOST  = 4;
  localparam int CB_DCACHE = 5;
  localparam int CB_BOOTF  = 6;
  localparam int CB_WDOG   = 7;
  localparam int CTRL_W    = 8;

  // cause register bit positions
  localparam int SB_DTRAP   = 3;
  localparam int SB_FTRAP   = 4;
  localparam int SB_MASKOVF = 29;
  localparam int SB_REQOVF  = 30;
  localparam int SB_MISS    = 31;

  localparam logic [31:0] HALT_MASK  = 32'h6000_0018;
  localparam logic [31:0] CAUSE_MASK = 32'hE000_0018;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h40;
  localparam logic [CTRL_W-1:0] WDOG_CLR   = 8'h8C;
endpackage

// File: rtl/dbg_low_page_trap.sv
module dbg_low_page_trap #(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic          vld,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW:0] LIMIT = PAGE_BYTES[AW:0];

  always_comb hit = vld && en && ({1'b0, addr} < LIMIT);
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import core_dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              wdog_evt,
  output logic [CTRL_W-1:2] ctrl_q,
  output logic              step_q,
  output logic              crst_q
);
  logic [CTRL_W-1:2] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wdata[CTRL_W-1:2];
    if (wdog_evt) ctrl_d = ctrl_d & ~WDOG_CLR[CTRL_W-1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET[CTRL_W-1:2];
      step_q <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      step_q <= wr_ctrl && wdata[CB_STEP];
      crst_q <= wr_ctrl && wdata[CB_CRST];
    end
  end

  assert_crst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (crst_q && !(wr_ctrl && wdata[CB_CRST])) |=> !crst_q);

  assert_wdog_clears_R10: assert property (@(posedge clk) disable iff (rst)
    wdog_evt |=> (!ctrl_q[CB_WDOG] && !ctrl_q[CB_FTRAP] && !ctrl_q[CB_DTRAP]));
endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg
  import core_dbg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] set_vec,
  input  logic [31:0] clr_vec,
  input  logic        step_next,
  output logic [31:0] cause_q,
  output logic        halt_q
);
  logic [31:0] cause_d;

  always_comb cause_d = ((cause_q & ~clr_vec) | set_vec) & CAUSE_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      halt_q  <= (|(cause_d & HALT_MASK)) && !step_next;
    end
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=>
      ((cause_q & $past(set_vec & CAUSE_MASK)) == $past(set_vec & CAUSE_MASK)));

  assert_miss_no_halt_R5: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & HALT_MASK) == '0 && (cause_q & HALT_MASK) == '0) |=> !halt_q);
endmodule

// File: rtl/core_halt_ctrl.sv
module core_halt_ctrl
  import core_dbg_pkg::*;
#(
  parameter int REG_AW     = 4,
  parameter int CORE_AW    = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               fetch_vld,
  input  logic [CORE_AW-1:0] fetch_addr,
  input  logic               dacc_vld,
  input  logic [CORE_AW-1:0] dacc_addr,
  input  logic               cache_miss,
  input  logic               req_fifo_ovf,
  input  logic               mask_fifo_ovf,
  input  logic               wdog_evt,
  output logic               core_halt,
  output logic               core_step,
  output logic               core_reset
);
  localparam logic [REG_AW-1:0] OFS_CTRL  = '0;
  localparam logic [REG_AW-1:0] OFS_CAUSE = REG_AW'(4);

  logic              wr_ctrl, wr_cause, step_next;
  logic [CTRL_W-1:2] ctrl_q;
  logic [31:0]       cause_q, set_vec, clr_vec;
  logic [1:0]        trap_hit, trap_en, trap_vld;
  logic [CORE_AW-1:0] trap_addr [2];

  always_comb begin
    wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    wr_cause  = bus_wr && (bus_addr == OFS_CAUSE);
    step_next = wr_ctrl && bus_wdata[CB_STEP];
    trap_vld  = {dacc_vld, fetch_vld};
    trap_en   = {ctrl_q[CB_DTRAP], ctrl_q[CB_FTRAP]};
    trap_addr[0] = fetch_addr;
    trap_addr[1] = dacc_addr;
  end

  for (genvar g = 0; g < 2; g++) begin : g_trap
    dbg_low_page_trap #(.AW(CORE_AW), .PAGE_BYTES(PAGE_BYTES)) trap_i (
      .vld (trap_vld[g]),
      .en  (trap_en[g]),
      .addr(trap_addr[g]),
      .hit (trap_hit[g])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[SB_FTRAP]   = trap_hit[0];
    set_vec[SB_DTRAP]   = trap_hit[1];
    set_vec[SB_REQOVF]  = req_fifo_ovf;
    set_vec[SB_MASKOVF] = mask_fifo_ovf;
    set_vec[SB_MISS]    = cache_miss;
    clr_vec = wr_cause ? bus_wdata : '0;
  end

  dbg_ctrl_reg ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata[CTRL_W-1:0]),
    .wdog_evt(wdog_evt),
    .ctrl_q  (ctrl_q),
    .step_q  (core_step),
    .crst_q  (core_reset)
  );

  dbg_cause_reg cause_i (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .step_next(step_next),
    .cause_q  (cause_q),
    .halt_q   (core_halt)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata <= {{(32-CTRL_W){1'b0}}, ctrl_q, core_reset, core_step};
        OFS_CAUSE: bus_rdata <= cause_q;
        default:   bus_rdata <= '0;
      endcase
    end else bus_rdata <= '0;
  end

  assert_ovf_halts_R4: assert property (@(posedge clk) disable iff (rst)
    ((req_fifo_ovf || mask_fifo_ovf) && !step_next) |=> core_halt);

  assert_step_release_R8: assert property (@(posedge clk) disable iff (rst)
    core_step |-> !core_halt);

  assert_halt_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    !core_step |-> (core_halt == (|(cause_q & HALT_MASK))));

  assert_fetch_trap_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && ctrl_q[CB_FTRAP] && (fetch_addr < CORE_AW'(PAGE_BYTES)))
      |=> cause_q[SB_FTRAP]);
endmodule

// File: tb/core_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_halt_ctrl_tb_top;
  localparam int REG_AW = 4;
  localparam int CORE_AW = 16;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [REG_AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fetch_vld = 0, dacc_vld = 0, cache_miss = 0;
  logic [CORE_AW-1:0] fetch_addr = '0, dacc_addr = '0;
  logic req_fifo_ovf = 0, mask_fifo_ovf = 0, wdog_evt = 0;
  logic core_halt, core_step, core_reset;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the registers
  logic [7:0]  m_ctrl = 8'h40;
  logic [31:0] m_cause = '0;
  logic m_step = 0, m_crst = 0, m_halt = 0;
  logic [31:0] m_rd = '0;

  always #2.5 clk = ~clk;

  core_halt_ctrl #(.REG_AW(REG_AW), .CORE_AW(CORE_AW)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_set();
    logic [31:0] s = '0;
    s[4]  = fetch_vld && m_ctrl[2] && (fetch_addr < 16'd256);
    s[3]  = dacc_vld && m_ctrl[3] && (dacc_addr < 16'd256);
    s[30] = req_fifo_ovf;
    s[29] = mask_fifo_ovf;
    s[31] = cache_miss;
    return s;
  endfunction

  function automatic logic [31:0] model_read();
    if (!bus_rd) return '0;
    if (bus_addr == 4'h0) return {24'h0, m_ctrl[7:2], m_crst, m_step};
    if (bus_addr == 4'h4) return m_cause;
    return '0;
  endfunction

  // one clock: advance model from current inputs, pass a posedge, idle inputs, compare
  task automatic tick();
    logic [31:0] set_v, clr_v;
    logic wr_c;
    set_v = model_set();
    m_rd = model_read();
    wr_c = bus_wr && bus_addr == 4'h0;
    clr_v = (bus_wr && bus_addr == 4'h4) ? bus_wdata : '0;
    m_cause = ((m_cause & ~clr_v) | set_v) & 32'hE000_0018;
    m_step = wr_c && bus_wdata[0];
    m_crst = wr_c && bus_wdata[1];
    if (wr_c) m_ctrl = bus_wdata[7:0] & 8'hFC;
    if (wdog_evt) m_ctrl = m_ctrl & ~8'h8C;
    m_halt = (|(m_cause & 32'h6000_0018)) && !m_step;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; fetch_vld = 0; dacc_vld = 0; cache_miss = 0;
    req_fifo_ovf = 0; mask_fifo_ovf = 0; wdog_evt = 0;
    chk("R7 halt", core_halt, m_halt);
    chk("R8 step", core_step, m_step);
    chk("R9 core reset", core_reset, m_crst);
    chk("R12 read data", bus_rdata, m_rd);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a; tick(); d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 halt", core_halt, 0);
    chk("R1 step", core_step, 0);
    chk("R1 reset out", core_reset, 0);
    rd(4'h0, v); chk("R1 ctrl", v, 32'h40);
    rd(4'h4, v); chk("R1 cause", v, 32'h0);

    // R2 fetch trap
    wr(4'h0, 32'h44);
    fetch_vld = 1; fetch_addr = 16'h0100; tick();
    chk("R2 addr 256 no trap", core_halt, 0);
    fetch_vld = 1; fetch_addr = 16'h00FF; tick();
    chk("R2 addr 255 halts", core_halt, 1);
    rd(4'h4, v); chk("R2 cause bit4", v, 32'h10);
    wr(4'h4, 32'h10); chk("R7 release", core_halt, 0);
    wr(4'h0, 32'h40);
    fetch_vld = 1; fetch_addr = 16'h0000; tick();
    rd(4'h4, v); chk("R2 disabled", v, 32'h0);

    // R3 data trap
    wr(4'h0, 32'h48);
    dacc_vld = 1; dacc_addr = 16'h1234; tick();
    rd(4'h4, v); chk("R3 high addr", v, 32'h0);
    dacc_vld = 1; dacc_addr = 16'h0000; tick();
    rd(4'h4, v); chk("R3 cause bit3", v, 32'h8);
    chk("R3 halt", core_halt, 1);
    wr(4'h4, 32'h8);
    wr(4'h0, 32'h40);

    // R4 overflows
    req_fifo_ovf = 1; tick(); chk("R4 req halt", core_halt, 1);
    mask_fifo_ovf = 1; tick();
    rd(4'h4, v); chk("R4 both bits", v, 32'h6000_0000);
    wr(4'h4, 32'h4000_0000); chk("R7 one left", core_halt, 1);
    wr(4'h4, 32'h2000_0000); chk("R7 all cleared", core_halt, 0);

    // R5 cache miss
    cache_miss = 1; tick(); chk("R5 no halt", core_halt, 0);
    rd(4'h4, v); chk("R5 bit31", v, 32'h8000_0000);

    // R6 write zero keeps, set wins over clear
    wr(4'h4, 32'h0);
    rd(4'h4, v); chk("R6 zero write", v, 32'h8000_0000);
    req_fifo_ovf = 1; tick();
    req_fifo_ovf = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = 32'hC000_0000; tick();
    rd(4'h4, v); chk("R6 set wins", v, 32'h4000_0000);

    // R8 single step re-halts, then resumes
    wr(4'h0, 32'h41); chk("R8 step pulse", core_step, 1); chk("R8 released", core_halt, 0);
    tick(); chk("R8 rehalt", core_halt, 1); chk("R8 step ends", core_step, 0);
    wr(4'h4, 32'h4000_0000);
    wr(4'h0, 32'h41); tick(); chk("R8 resume", core_halt, 0);

    // R9 core reset pulse
    wr(4'h0, 32'h72); chk("R9 pulse", core_reset, 1);
    tick(); chk("R9 self clear", core_reset, 0);
    rd(4'h0, v); chk("R9 ctrl kept", v, 32'h70);

    // R10 watchdog, R11 read/write bits
    wr(4'h0, 32'hFC);
    wdog_evt = 1; tick();
    rd(4'h0, v); chk("R10 wdog clear", v, 32'h70);
    wdog_evt = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'h8C; tick();
    rd(4'h0, v); chk("R10 wdog wins", v, 32'h0);
    wr(4'h0, 32'h30); rd(4'h0, v); chk("R11 rw bits", v, 32'h30);
    wr(4'h0, 32'h40); rd(4'h0, v); chk("R11 boot flag", v, 32'h40);

    // R12 unused offset
    wr(4'h8, 32'hFF); rd(4'h0, v); chk("R12 write ignored", v, 32'h40);
    rd(4'h8, v); chk("R12 unused read", v, 32'h0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      fetch_vld = ($urandom % 4) == 0; fetch_addr = 16'($urandom % 512);
      dacc_vld = ($urandom % 4) == 0;  dacc_addr = 16'($urandom % 512);
      cache_miss = ($urandom % 8) == 0;
      req_fifo_ovf = ($urandom % 16) == 0;
      mask_fifo_ovf = ($urandom % 16) == 0;
      wdog_evt = ($urandom % 32) == 0;
      bus_wr = ($urandom % 3) == 0;
      bus_rd = ($urandom % 2) == 0;
      bus_addr = 4'(($urandom % 3) * 4);
      bus_wdata = $urandom;
      if (bus_addr == 4'h0 && ($urandom % 4) != 0) bus_wdata[1:0] = 2'b00;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule